// File: doc/BRIEF.md
# Secured Program Memory Access Gate

This block stands between an external programming and read-back port and three on-chip storage areas: the program (code) memory, a one-byte option register and a small user information area. Each port operation selects one area through a space code, gives an address and, for a write, a data byte. A write programs the addressed byte by OR-ing the new data into it, because cells only move from the erased to the programmed state. An erase strobe blanks the storage.

The option register carries a security bit. Once it is programmed, external reads of code memory return all ones, and code and option writes are dropped. The option register and the user bytes stay visible, and the user bytes stay writable. Security cannot be undone: erase clears everything except that bit, so a secured and erased part stays blank and cannot be programmed again. The remaining option fields leave the block as decoded configuration outputs. Each read is answered one clock cycle after its strobe.

Top module: `prog_sec_gate`

## Requirements
- R1: A read strobe raised alone for one cycle yields rsp_valid_o high in the next cycle with the addressed byte on rdata_o. Unsecured code reads return the stored byte. rsp_valid_o is low in every other cycle, and rdata_o is 0x00 then.
- R2: A write ORs wdata_i into the addressed byte of code memory (space 0), the option register (space 1) or the user area (space 2), so later writes can only add ones.
- R3: Code addresses at or above CODE_BYTES, user addresses at or above USER_BYTES, option addresses other than 0, and space code 3 all read 0xFF, and writes to them change nothing.
- R4: While the security bit is set, every code memory read returns 0xFF.
- R5: While the security bit is set, option register writes are ignored.
- R6: The option register reads back at any time with this layout: bit 6 power-on-reset enable (por_en_o), bit 5 security (secured_o), bits 4:3 clock select (clk_sel_o), bit 2 watchdog off (wdog_off_o), bit 0 halt off (halt_off_o). Bits 7 and 1 always read 0.
- R7: The user bytes can be read and written whether or not the part is secured.
- R8: Once the security bit is set, it stays set through later option writes and through erase.
- R9: Erase sets every code and user byte to 0x00 and clears every option bit except the security bit.
- R10: When strobes coincide, erase wins over write and write wins over read. A read that loses gives no response, and a write that loses to erase is dropped.
- R11: After reset every byte reads 0x00, the part is unsecured, all option outputs are 0 and rsp_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, models a blank part |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write (program) strobe |
| erase_i | input | 1 | Erase strobe |
| space_i | input | 2 | Area select: 0 code, 1 option, 2 user, 3 none |
| addr_i | input | ADDR_W | Byte address within the selected area |
| wdata_i | input | 8 | Data to program |
| rsp_valid_o | output | 1 | Read response valid |
| rdata_o | output | 8 | Read response data |
| secured_o | output | 1 | Security bit |
| por_en_o | output | 1 | Power-on-reset enable option |
| clk_sel_o | output | 2 | Clock select option |
| wdog_off_o | output | 1 | Watchdog disable option |
| halt_off_o | output | 1 | Halt disable option |

## Verification
The bench builds the block with CODE_BYTES=16 and ADDR_W=8. This lets every code byte be programmed and read back in a few hundred cycles. It also puts addresses both just past the array and far past it within reach. Address 20 is chosen because its low bits alias byte 4, so a missing range check would corrupt a byte the bench reads afterwards. The test erases the part once while unsecured, so that blank code reads as 0x00, and again after security is set, to show that the bit survives erase.

// File: rtl/psg_pkg.sv
package psg_pkg;
  typedef enum logic [1:0] {
    SP_CODE = 2'd0,
    SP_OPT  = 2'd1,
    SP_USER = 2'd2,
    SP_NONE = 2'd3
  } space_e;

  localparam int unsigned LOCK_BIT = 5;
  localparam int unsigned POR_BIT  = 6;
  localparam int unsigned CLK_LSB  = 3;
  localparam int unsigned WDOG_BIT = 2;
  localparam int unsigned HALT_BIT = 0;
  // implemented option bits; 7 and 1 are reserved
  localparam logic [7:0] OPT_WMASK = 8'h7D;
  localparam logic [7:0] LOCK_MASK = 8'h01 << LOCK_BIT;
  localparam logic [7:0] BLANK_RD  = 8'hFF;
endpackage

// File: rtl/psg_byte_array.sv
module psg_byte_array #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= mem_q[idx_i] | wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];

  // R9
  erase_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rdata_o == 8'h00));

  // R2
  or_program_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clr_i) |=> ((rdata_o & $past(wdata_i)) == $past(wdata_i)) || $changed(idx_i));
endmodule

// File: rtl/psg_opt_reg.sv
module psg_opt_reg
  import psg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] opt_o
);
  logic [7:0] opt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    opt_q <= '0;
    else if (clr_i) opt_q <= opt_q & LOCK_MASK;
    else if (we_i)  opt_q <= opt_q | (wdata_i & OPT_WMASK);
  end

  assign opt_o = opt_q;

  // R8
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opt_q[LOCK_BIT] |=> opt_q[LOCK_BIT]);

  // R6
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opt_q & ~OPT_WMASK) == 8'h00);
endmodule

// File: rtl/prog_sec_gate.sv
module prog_sec_gate
  import psg_pkg::*;
#(
  parameter int unsigned CODE_BYTES = 64,
  parameter int unsigned USER_BYTES = 8,
  parameter int unsigned ADDR_W     = 12,
  localparam int unsigned CIW = (CODE_BYTES > 1) ? $clog2(CODE_BYTES) : 1,
  localparam int unsigned UIW = (USER_BYTES > 1) ? $clog2(USER_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              erase_i,
  input  logic [1:0]        space_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              rsp_valid_o,
  output logic [7:0]        rdata_o,
  output logic              secured_o,
  output logic              por_en_o,
  output logic [1:0]        clk_sel_o,
  output logic              wdog_off_o,
  output logic              halt_off_o
);
  space_e     space;
  logic       wr_go, rd_go;
  logic       code_hit, user_hit, opt_hit;
  logic       code_we, user_we, opt_we;
  logic [7:0] code_rd, user_rd, opt_q;
  logic [7:0] rd_mux;
  logic       rsp_valid_q;
  logic [7:0] rdata_q;

  assign space = space_e'(space_i);

  // erase > write > read
  assign wr_go = wr_i & ~erase_i;
  assign rd_go = rd_i & ~wr_i & ~erase_i;

  assign code_hit = (space == SP_CODE) && (32'(addr_i) < 32'(CODE_BYTES));
  assign user_hit = (space == SP_USER) && (32'(addr_i) < 32'(USER_BYTES));
  assign opt_hit  = (space == SP_OPT)  && (addr_i == '0);

  assign code_we = wr_go & code_hit & ~secured_o;
  assign opt_we  = wr_go & opt_hit  & ~secured_o;
  assign user_we = wr_go & user_hit;

  psg_byte_array #(.DEPTH(CODE_BYTES)) i_code (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (erase_i),
    .we_i    (code_we),
    .idx_i   (addr_i[CIW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (code_rd)
  );

  psg_byte_array #(.DEPTH(USER_BYTES)) i_user (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (erase_i),
    .we_i    (user_we),
    .idx_i   (addr_i[UIW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (user_rd)
  );

  psg_opt_reg i_opt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (erase_i),
    .we_i    (opt_we),
    .wdata_i (wdata_i),
    .opt_o   (opt_q)
  );

  always_comb begin
    rd_mux = BLANK_RD;
    unique case (space)
      SP_CODE: if (code_hit) rd_mux = secured_o ? BLANK_RD : code_rd;
      SP_OPT:  if (opt_hit)  rd_mux = opt_q;
      SP_USER: if (user_hit) rd_mux = user_rd;
      default: rd_mux = BLANK_RD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= rd_go;
      rdata_q     <= rd_go ? rd_mux : 8'h00;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rdata_o     = rdata_q;
  assign secured_o   = opt_q[LOCK_BIT];
  assign por_en_o    = opt_q[POR_BIT];
  assign clk_sel_o   = opt_q[CLK_LSB +: 2];
  assign wdog_off_o  = opt_q[WDOG_BIT];
  assign halt_off_o  = opt_q[HALT_BIT];

  // R10
  lose_no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || erase_i) |=> !rsp_valid_o);

  // R4
  code_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && !erase_i && space_i == 2'd0 && secured_o) |=> (rdata_o == 8'hFF));

  // R5
  opt_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !erase_i && secured_o) |=> $stable(opt_q));

  // R3
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && !erase_i && space_i == 2'd0 && 32'(addr_i) >= 32'(CODE_BYTES))
      |=> (rsp_valid_o && rdata_o == 8'hFF));
endmodule

// File: tb/test_prog_sec_gate.sv
module test_prog_sec_gate;
  localparam int unsigned NCODE = 16;
  localparam int unsigned NUSER = 8;
  localparam int unsigned AW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd = 1'b0, wr = 1'b0, er = 1'b0;
  logic [1:0]    space = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic          rsp_valid, secured, por_en, wdog_off, halt_off;
  logic [1:0]    clk_sel;
  logic [7:0]    rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic [7:0] code_m [NCODE];
  logic [7:0] user_m [NUSER];
  logic [7:0] opt_m;

  always #5 clk = ~clk;

  prog_sec_gate #(.CODE_BYTES(NCODE), .USER_BYTES(NUSER), .ADDR_W(AW)) i_prog_sec_gate (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .erase_i(er),
    .space_i(space), .addr_i(addr), .wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rdata_o(rdata), .secured_o(secured),
    .por_en_o(por_en), .clk_sel_o(clk_sel), .wdog_off_o(wdog_off), .halt_off_o(halt_off)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] sp, input logic [AW-1:0] a);
    case (sp)
      2'd0: return (a < NCODE) ? (opt_m[5] ? 8'hFF : code_m[a]) : 8'hFF;
      2'd1: return (a == 0) ? opt_m : 8'hFF;
      2'd2: return (a < NUSER) ? user_m[a] : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic op(input logic r, input logic w, input logic e,
                    input logic [1:0] sp, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    rd = r; wr = w; er = e; space = sp; addr = a; wdata = d;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0; er = 1'b0;
  endtask

  task automatic model_wr(input logic [1:0] sp, input logic [AW-1:0] a, input logic [7:0] d);
    case (sp)
      2'd0: if (a < NCODE && !opt_m[5]) code_m[a] = code_m[a] | d;
      2'd1: if (a == 0 && !opt_m[5]) opt_m = opt_m | (d & 8'h7D);
      2'd2: if (a < NUSER) user_m[a] = user_m[a] | d;
      default: ;
    endcase
  endtask

  task automatic model_erase();
    for (int i = 0; i < NCODE; i++) code_m[i] = 8'h00;
    for (int i = 0; i < NUSER; i++) user_m[i] = 8'h00;
    opt_m = opt_m & 8'h20;
  endtask

  task automatic wr_byte(input logic [1:0] sp, input logic [AW-1:0] a, input logic [7:0] d);
    model_wr(sp, a, d);
    op(1'b0, 1'b1, 1'b0, sp, a, d);
  endtask

  task automatic rd_byte(input logic [1:0] sp, input logic [AW-1:0] a, input string tag);
    exp_q.push_back(exp_read(sp, a));
    tag_q.push_back(tag);
    op(1'b1, 1'b0, 1'b0, sp, a, 8'h00);
  endtask

  task automatic erase_all();
    model_erase();
    op(1'b0, 1'b0, 1'b1, 2'd0, '0, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R10 unexpected response act=%0h exp=none", rdata);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, rdata, e);
        end
      end else begin
        if (rdata !== 8'h00) chk("R1 idle data", rdata, 8'h00);
      end
    end
  end

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCODE; i++) code_m[i] = 8'h00;
    for (int i = 0; i < NUSER; i++) user_m[i] = 8'h00;
    opt_m = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 rsp_valid", rsp_valid, 0);
    chk("R11 secured", secured, 0);
    chk("R11 options", {por_en, clk_sel, wdog_off, halt_off}, 0);
    rd_byte(2'd0, 8'd0, "R11 blank code");
    rd_byte(2'd1, 8'd0, "R11 blank option");

    // R1 R2 program and read all code bytes
    for (int i = 0; i < NCODE; i++) wr_byte(2'd0, AW'(i), 8'(8'h11 * i + 8'h03));
    for (int i = 0; i < NCODE; i++) rd_byte(2'd0, AW'(i), "R1 code readback");
    wr_byte(2'd0, 8'd3, 8'hF0);
    rd_byte(2'd0, 8'd3, "R2 code or-program");

    // R3 out of range
    wr_byte(2'd0, 8'd20, 8'hA5);
    rd_byte(2'd0, 8'd4, "R3 alias byte untouched");
    rd_byte(2'd0, 8'd16, "R3 code just past end");
    rd_byte(2'd0, 8'd200, "R3 code far past end");
    rd_byte(2'd2, 8'd9, "R3 user past end");
    rd_byte(2'd1, 8'd1, "R3 option nonzero addr");
    rd_byte(2'd3, 8'd0, "R3 space none");
    wr_byte(2'd1, 8'd1, 8'h20);
    chk("R3 option alias write", secured, 0);

    // R7 R2 user area unsecured
    wr_byte(2'd2, 8'd5, 8'h0C);
    wr_byte(2'd2, 8'd5, 8'h30);
    rd_byte(2'd2, 8'd5, "R7 user or-program");

    // R6 option fields and reserved bits
    wr_byte(2'd1, 8'd0, 8'h48);
    wr_byte(2'd1, 8'd0, 8'h15);
    wr_byte(2'd1, 8'd0, 8'h82);
    rd_byte(2'd1, 8'd0, "R6 option readback");
    chk("R6 por_en", por_en, 1);
    chk("R6 clk_sel", clk_sel, 3);
    chk("R6 wdog_off", wdog_off, 1);
    chk("R6 halt_off", halt_off, 1);
    chk("R6 secured clear", secured, 0);

    // R9 unsecured erase
    erase_all();
    rd_byte(2'd0, 8'd7, "R9 code erased");
    rd_byte(2'd2, 8'd5, "R9 user erased");
    rd_byte(2'd1, 8'd0, "R9 option erased");
    chk("R9 options low", {por_en, clk_sel, wdog_off, halt_off}, 0);

    // R10 priority
    exp_q.push_back(8'h00); tag_q.push_back("R10 placeholder");
    void'(exp_q.pop_back()); void'(tag_q.pop_back());
    model_wr(2'd2, 8'd1, 8'h80);
    op(1'b1, 1'b1, 1'b0, 2'd2, 8'd1, 8'h80);
    chk("R10 write beats read", rsp_valid, 0);
    rd_byte(2'd2, 8'd1, "R10 write applied");
    model_erase();
    op(1'b1, 1'b1, 1'b1, 2'd2, 8'd2, 8'h42);
    chk("R10 erase beats all", rsp_valid, 0);
    rd_byte(2'd2, 8'd2, "R10 write dropped by erase");
    rd_byte(2'd2, 8'd1, "R10 erase cleared user");

    // secure the part
    wr_byte(2'd0, 8'd9, 8'h5A);
    rd_byte(2'd0, 8'd9, "R1 code before lock");
    wr_byte(2'd1, 8'd0, 8'h24);
    chk("R6 secured set", secured, 1);
    rd_byte(2'd0, 8'd9, "R4 code masked");
    rd_byte(2'd0, 8'd0, "R4 blank code masked");
    rd_byte(2'd1, 8'd0, "R6 option readable secured");
    wr_byte(2'd1, 8'd0, 8'h40);
    rd_byte(2'd1, 8'd0, "R5 option write ignored");
    chk("R5 por_en held", por_en, 0);
    wr_byte(2'd2, 8'd6, 8'h81);
    rd_byte(2'd2, 8'd6, "R7 user write secured");

    // R8 secured erase
    erase_all();
    chk("R8 lock survives erase", secured, 1);
    chk("R9 wdog cleared", wdog_off, 0);
    rd_byte(2'd1, 8'd0, "R8 option after erase");
    rd_byte(2'd2, 8'd6, "R9 user erased secured");
    wr_byte(2'd0, 8'd9, 8'hFF);
    rd_byte(2'd0, 8'd9, "R4 code masked after erase");
    wr_byte(2'd2, 8'd0, 8'h3C);
    rd_byte(2'd2, 8'd0, "R7 user after secured erase");

    repeat (3) @(negedge clk);
    chk("R1 all responses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule